// File: doc/BRIEF.md
# Three-Channel Reset/Set PWM Timer

This block is an up-counting timer that drives several pulse-width-modulated outputs from one shared count. The count starts at zero, climbs by one every clock and, in the cycle after it has equalled the programmed period value, starts again at zero. One pass from zero to the period value is one PWM cycle. Each channel has its own compare value. Its output is set high when the count wraps to zero. It is cleared in the cycle in which the count equals that compare value. The high time of each output is therefore its compare value in clock cycles, out of period+1.

Software or a sequencer writes the period and the compare values through a small write-only register port. Writes go to shadow copies, and all shadows move into the active registers together at the wrap. A strobe marks the last cycle of each PWM cycle, so that a new sample (for example the next point of a waveform table) can be written once per cycle without producing split or doubled pulses. The reset period gives a 256-cycle PWM cycle: with a 2.048 MHz clock this is an 8 kHz PWM rate. Filtering each output turns it into an analog level.

Top module: `pwm_rs_timer`

## Requirements
- R1: The counter counts 0, 1, 2, … up to the active period value P. On the next clock it returns to 0, so one PWM cycle is P+1 clocks (P=0 gives a one-clock cycle).
- R2: After reset the period value is 255, so each PWM cycle is 256 clocks until software writes a new period.
- R3: A channel output is low in every cycle of a PWM cycle in which the count is greater than or equal to a nonzero compare value C of that channel. It goes low in the cycle in which the count equals C.
- R4: A channel output is high from count 0 up to count C-1, so it is high for exactly C clocks per PWM cycle. C=0 keeps it low for the whole cycle.
- R5: A compare value greater than P keeps the output high for the whole PWM cycle (P+1 clocks).
- R6: The period-end strobe `cycle_end_o` is high for exactly one clock per PWM cycle: the clock in which the count equals P.
- R7: A write with `wr_en`=1 stores `wr_data` in a shadow register. Address 0 selects the period, and address k (1 to 3) selects the compare value of channel k-1. Shadows become active at the next wrap, so a write never changes the PWM cycle in progress.
- R8: A write on the clock edge that ends a PWM cycle (the edge after the strobe) only reaches the shadow. The cycle that starts at that edge still uses the earlier values, and the new value applies one PWM cycle later.
- R9: Writes to addresses 4 to 7 change nothing: period, compare values and outputs stay as before.
- R10: A synchronous active-high reset puts the count at 0, the period at 255 and every compare value (active and shadow) at 0, and drives all outputs low from the next cycle.
- R11: The three channels are independent. Each output's high time depends only on its own compare value and the shared period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select: 0 period, 1..3 channel compare |
| wr_data | input | 8 | Value written |
| pwm_o | output | 3 | PWM outputs, bit k is channel k |
| cycle_end_o | output | 1 | High in the last clock of each PWM cycle |

## Verification
The bench measures whole PWM cycles at the pins: their length and the high time of each output. It does this for compare values of zero, equal to the period, one above it and far above it, and for periods of 0, 1, 9, 31 and 255. Getting a boundary wrong shows up as an off-by-one high time, a one-clock glitch for a zero compare, or a clipped pulse for an oversized compare. Writes are placed mid-cycle and exactly on the wrap edge: a design without shadowing would change the cycle in progress, and one that loaded the shadow at the wrong edge would apply a value one cycle early. Writes to unused addresses and a reset in the middle of a cycle check that nothing leaks into the period or the compare values.

// File: rtl/pwm_rs_pkg.sv
package pwm_rs_pkg;

   // register slot of the shared period value
   localparam int unsigned PRD_SLOT = 0;

   // register slot of a channel's compare value
   function automatic int unsigned cmp_slot(input int unsigned ch);
      return ch + 1;
   endfunction

   // number of register slots used for a channel count
   function automatic int unsigned slots_used(input int unsigned nch);
      return nch + 1;
   endfunction

endpackage

// File: rtl/pwm_rs_counter.sv
module pwm_rs_counter #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [CNT_W-1:0] per_act,
   output logic [CNT_W-1:0] cnt_q,
   output logic [CNT_W-1:0] cnt_nxt,
   output logic             wrap_o
);

   assign wrap_o  = (cnt_q == per_act);
   assign cnt_nxt = wrap_o ? '0 : cnt_q + 1'b1;

   always_ff @(posedge clk) begin
      if (rst) cnt_q <= '0;
      else     cnt_q <= cnt_nxt;
   end

endmodule

// File: rtl/pwm_rs_shadow.sv
module pwm_rs_shadow #(
   parameter int unsigned     W       = 8,
   parameter logic [W-1:0]    RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         wr,
   input  logic [W-1:0] wdata,
   input  logic         load,
   output logic [W-1:0] shad_q,
   output logic [W-1:0] act_q
);

   // shadow takes writes at any time; active follows it only at the wrap
   always_ff @(posedge clk) begin
      if (rst) begin
         shad_q <= RST_VAL;
         act_q  <= RST_VAL;
      end else begin
         if (wr)   shad_q <= wdata;
         if (load) act_q  <= shad_q;
      end
   end

endmodule

// File: rtl/pwm_rs_channel.sv
module pwm_rs_channel #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             wrap,
   input  logic [CNT_W-1:0] cnt_nxt,
   input  logic [CNT_W-1:0] cmp_act,
   input  logic [CNT_W-1:0] cmp_shad,
   output logic             pwm_q
);

   // set at wrap (unless the incoming compare is zero), clear on match
   always_ff @(posedge clk) begin
      if (rst)                       pwm_q <= 1'b0;
      else if (wrap)                 pwm_q <= (cmp_shad != '0);
      else if (cnt_nxt == cmp_act)   pwm_q <= 1'b0;
   end

endmodule

// File: rtl/pwm_rs_timer.sv
module pwm_rs_timer #(
   parameter int unsigned CNT_W      = 8,
   parameter int unsigned NUM_CH     = 3,
   parameter int unsigned ADDR_W     = 3,
   parameter int unsigned PERIOD_RST = (1 << CNT_W) - 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [CNT_W-1:0]  wr_data,
   output logic [NUM_CH-1:0] pwm_o,
   output logic              cycle_end_o
);
   import pwm_rs_pkg::*;

   localparam int unsigned N_SLOTS = slots_used(NUM_CH);
   localparam int unsigned CMP_W   = NUM_CH * CNT_W;

   if (CNT_W < 2 || CNT_W > 16) begin : g_bad_cnt_w
      $error("pwm_rs_timer: CNT_W must be 2..16");
   end
   if (NUM_CH < 1) begin : g_bad_nch
      $error("pwm_rs_timer: NUM_CH must be at least 1");
   end
   if ((1 << ADDR_W) < N_SLOTS) begin : g_bad_addr_w
      $error("pwm_rs_timer: ADDR_W too small for NUM_CH+1 slots");
   end
   if (PERIOD_RST >= (1 << CNT_W)) begin : g_bad_prd
      $error("pwm_rs_timer: PERIOD_RST does not fit CNT_W");
   end

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_nxt;
   logic [CNT_W-1:0] per_act;
   logic [CNT_W-1:0] per_shad;
   logic             wrap;
   logic             per_wr;
   logic [CMP_W-1:0] cmp_act_flat;

   assign per_wr = wr_en && (wr_addr == ADDR_W'(PRD_SLOT));

   pwm_rs_counter #(.CNT_W(CNT_W)) i_cnt (
      .clk     (clk),
      .rst     (rst),
      .per_act (per_act),
      .cnt_q   (cnt_q),
      .cnt_nxt (cnt_nxt),
      .wrap_o  (wrap)
   );

   pwm_rs_shadow #(.W(CNT_W), .RST_VAL(CNT_W'(PERIOD_RST))) i_prd (
      .clk    (clk),
      .rst    (rst),
      .wr     (per_wr),
      .wdata  (wr_data),
      .load   (wrap),
      .shad_q (per_shad),
      .act_q  (per_act)
   );

   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
      logic             cmp_wr;
      logic [CNT_W-1:0] cmp_shad;
      logic [CNT_W-1:0] cmp_act;

      assign cmp_wr = wr_en && (wr_addr == ADDR_W'(cmp_slot(ch)));

      pwm_rs_shadow #(.W(CNT_W), .RST_VAL('0)) i_cmp (
         .clk    (clk),
         .rst    (rst),
         .wr     (cmp_wr),
         .wdata  (wr_data),
         .load   (wrap),
         .shad_q (cmp_shad),
         .act_q  (cmp_act)
      );

      pwm_rs_channel #(.CNT_W(CNT_W)) i_chan (
         .clk      (clk),
         .rst      (rst),
         .wrap     (wrap),
         .cnt_nxt  (cnt_nxt),
         .cmp_act  (cmp_act),
         .cmp_shad (cmp_shad),
         .pwm_q    (pwm_o[ch])
      );

      assign cmp_act_flat[ch*CNT_W +: CNT_W] = cmp_act;
   end

   assign cycle_end_o = wrap;

   // per_shad is consumed inside the shadow instance only
   logic unused_shad;
   assign unused_shad = ^per_shad;

endmodule

// File: rtl/pwm_rs_checker.sv
module pwm_rs_checker #(
   parameter int unsigned CNT_W      = 8,
   parameter int unsigned NUM_CH     = 3,
   parameter int unsigned PERIOD_RST = 255
) (
   input logic                    clk,
   input logic                    rst,
   input logic [CNT_W-1:0]        cnt,
   input logic [CNT_W-1:0]        per_act,
   input logic [NUM_CH*CNT_W-1:0] cmp_flat,
   input logic [NUM_CH-1:0]       pwm,
   input logic                    prd_end
);

   assert_cnt_in_range_R1: assert property (@(posedge clk) disable iff (rst)
      cnt <= per_act);

   assert_wrap_to_zero_R1: assert property (@(posedge clk) disable iff (rst)
      prd_end |=> (cnt == '0));

   assert_count_step_R1: assert property (@(posedge clk) disable iff (rst)
      !prd_end |=> (cnt == CNT_W'($past(cnt) + 1'b1)));

   assert_hold_midcycle_R7: assert property (@(posedge clk) disable iff (rst)
      !prd_end |=> ($stable(cmp_flat) && $stable(per_act)));

   assert_reset_state_R10: assert property (@(posedge clk)
      rst |=> (cnt == '0 && pwm == '0 && cmp_flat == '0
               && per_act == CNT_W'(PERIOD_RST)));

   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chk
      logic [CNT_W-1:0] cmp_i;
      assign cmp_i = cmp_flat[ch*CNT_W +: CNT_W];

      assert_clear_on_match_R3: assert property (@(posedge clk) disable iff (rst)
         (cnt == cmp_i && cnt != '0) |-> !pwm[ch]);

      assert_set_at_wrap_R4: assert property (@(posedge clk) disable iff (rst)
         prd_end |=> (pwm[ch] == (cmp_i != '0)));

      assert_zero_low_R4: assert property (@(posedge clk) disable iff (rst)
         (cmp_i == '0) |-> !pwm[ch]);

      assert_above_period_high_R5: assert property (@(posedge clk) disable iff (rst)
         (cmp_i > per_act) |-> pwm[ch]);
   end

endmodule

bind pwm_rs_timer pwm_rs_checker #(
   .CNT_W      (CNT_W),
   .NUM_CH     (NUM_CH),
   .PERIOD_RST (PERIOD_RST)
) i_pwm_rs_checker (
   .clk      (clk),
   .rst      (rst),
   .cnt      (cnt_q),
   .per_act  (per_act),
   .cmp_flat (cmp_act_flat),
   .pwm      (pwm_o),
   .prd_end  (cycle_end_o)
);

// File: tb/test_pwm_rs_timer.sv
`timescale 1ns/1ps
module test_pwm_rs_timer;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       wr_en = 1'b0;
   logic [2:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic [2:0] pwm_o;
   logic       cycle_end_o;

   int total = 0;
   int bad   = 0;
   int clk_cnt = 0;
   int m_cyc;
   int m_hi [3];

   always #2.5 clk = ~clk;

   pwm_rs_timer i_pwm_rs_timer (
      .clk         (clk),
      .rst         (rst),
      .wr_en       (wr_en),
      .wr_addr     (wr_addr),
      .wr_data     (wr_data),
      .pwm_o       (pwm_o),
      .cycle_end_o (cycle_end_o)
   );

   // rows: period, compare ch0, ch1, ch2
   localparam int NV = 7;
   localparam int VEC [NV][4] = '{
      '{255,   0, 128, 255},
      '{  9,   3,   0,  10},
      '{  9,  12,   9,   1},
      '{  0,   0,   1,   2},
      '{  1,   1,   0,   2},
      '{ 31,  16,  31,   5},
      '{  9,   3,   6,  10}
   };

   always @(posedge clk) begin
      clk_cnt++;
      if (clk_cnt > 150000) begin
         bad++;
         total++;
         $display("FAIL watchdog: run did not finish (actual %0d cycles, expected < 150000)", clk_cnt);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int exp_hi(input int c, input int p);
      return (c > p + 1) ? p + 1 : c;
   endfunction

   task automatic reg_wr(input logic [2:0] a, input logic [7:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic wait_end();
      while (!cycle_end_o) @(negedge clk);
   endtask

   // call at a negedge where cycle_end_o is high; measures the next cycle.
   // wr_at: -1 none, 0 on the wrap edge starting it, k after k samples
   task automatic measure(input int wr_at, input logic [2:0] wa, input logic [7:0] wd);
      int idx = 0;
      m_cyc = 0;
      for (int k = 0; k < 3; k++) m_hi[k] = 0;
      if (wr_at == 0) begin wr_en = 1'b1; wr_addr = wa; wr_data = wd; end
      do begin
         @(negedge clk);
         wr_en = 1'b0;
         m_cyc++;
         for (int k = 0; k < 3; k++) if (pwm_o[k]) m_hi[k]++;
         idx++;
         if (idx == wr_at) begin wr_en = 1'b1; wr_addr = wa; wr_data = wd; end
      end while (!cycle_end_o && m_cyc < 5000);
   endtask

   task automatic chk_cycle(input string req, input int p, input int c0, input int c1, input int c2);
      chk({req, " R1 cycle length"}, m_cyc, p + 1);
      chk({req, " ch0 high"}, m_hi[0], exp_hi(c0, p));
      chk({req, " ch1 high"}, m_hi[1], exp_hi(c1, p));
      chk({req, " ch2 high"}, m_hi[2], exp_hi(c2, p));
   endtask

   initial begin
      // R10 reset state
      repeat (3) @(negedge clk);
      chk("R10 outputs low in reset", int'(pwm_o), 0);
      chk("R10 strobe low in reset", int'(cycle_end_o), 0);
      rst = 1'b0;
      wait_end();
      // R2 default period, R10 cleared compares
      measure(-1, 3'd0, 8'd0);
      chk_cycle("R2 default period", 255, 0, 0, 0);

      // vector table: R1 R3 R4 R5 R6 R11
      for (int v = 0; v < NV; v++) begin
         reg_wr(3'd0, 8'(VEC[v][0]));
         reg_wr(3'd1, 8'(VEC[v][1]));
         reg_wr(3'd2, 8'(VEC[v][2]));
         reg_wr(3'd3, 8'(VEC[v][3]));
         wait_end();
         measure(-1, 3'd0, 8'd0);
         chk_cycle($sformatf("R3 R4 R5 R11 vec%0d", v), VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3]);
      end
      // now P=9, compares 3,6,10

      // R6: strobe is high for a single clock
      @(negedge clk);
      chk("R6 strobe drops after one clock", int'(cycle_end_o), 0);
      wait_end();

      // R7: mid-cycle write does not affect current cycle
      measure(2, 3'd1, 8'd7);
      chk_cycle("R7 current cycle unchanged", 9, 3, 6, 10);
      measure(-1, 3'd0, 8'd0);
      chk_cycle("R7 new value next cycle", 9, 7, 6, 10);

      // R8: write on the wrap edge lands one cycle later
      measure(10, 3'd1, 8'd2);
      chk_cycle("R8 before", 9, 7, 6, 10);
      measure(-1, 3'd0, 8'd0);
      chk_cycle("R8 cycle after wrap write still old", 9, 7, 6, 10);
      measure(-1, 3'd0, 8'd0);
      chk_cycle("R8 applied one cycle later", 9, 2, 6, 10);

      // R9: unused addresses ignored
      measure(3, 3'd5, 8'd0);
      measure(4, 3'd7, 8'd1);
      measure(-1, 3'd0, 8'd0);
      chk_cycle("R9 unused address no effect", 9, 2, 6, 10);

      // R10: reset mid-cycle
      repeat (4) @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      chk("R10 outputs low after reset", int'(pwm_o), 0);
      chk("R10 strobe low after reset", int'(cycle_end_o), 0);
      rst = 1'b0;
      wait_end();
      measure(-1, 3'd0, 8'd0);
      chk_cycle("R10 period and compares restored", 255, 0, 0, 0);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule